// File: doc/BRIEF.md
# Two-Channel Frame-Synchronised PCM Serial Port

This block moves two 8-bit voice samples per frame across one shared bit clock. A single frame-sync pulse starts each frame. After it, sixteen data bits follow on each direction: transmit on a serial output with an enable, and receive on a serial input. The two parallel transmit words are captured when the pulse is seen. They are shifted out most significant bit first, in the two 8-bit slots of the frame. The receive line is deserialised into two bytes, and each byte comes with a one-cycle valid strobe.

The length of the frame-sync pulse decides which channel takes the first slot. A pulse one clock long puts channel 0 first. A pulse two or more clocks long puts channel 1 first. The same order applies to transmit and receive for the whole frame. Data uses delayed timing: the first bit appears one clock after frame sync rises. Transmit bits change on the rising clock edge and receive bits are sampled on the falling edge. Outside the sixteen data bits the transmit enable is low, so an outer pad can tri-state the line.

Top module: `pcm_tdm_port`

## Requirements
- R1: `dx_en_o` is high for exactly 16 consecutive clocks per accepted frame and low at all other times. While it is low, `dx_o` is 0.
- R2: If `fs_i` is sampled low on the edge after the edge that detected its rise (one-clock pulse), the first 8 transmitted bits are channel 0's word, MSB first, and the next 8 are channel 1's word.
- R3: If `fs_i` is still high on that second edge (pulse of two or more clocks), channel 1's word is sent first and channel 0's second, each MSB first.
- R4: A frame starts on a rising edge that samples `fs_i` high after sampling it low one edge earlier. The first data bit is driven from the next rising edge (delayed timing).
- R5: The transmit words are sampled on the edge that detects the frame-sync rise. Later changes on `tx_ch0_i`/`tx_ch1_i` have no effect on the frame in flight.
- R6: `dr_i` is sampled on falling edges; bit n of the frame is sampled in the middle of the clock in which transmit bit n is driven. The first slot's byte and its valid strobe appear 9 clocks after the frame-detecting edge. The second slot's byte and strobe appear 17 clocks after it. Each strobe lasts one clock and the two strobes never coincide.
- R7: While a frame is in progress, the frame sync staying high or rising again neither restarts nor shifts the frame.
- R8: After reset, `dx_en_o`, `dx_o`, both valid strobes and both received bytes are 0.
- R9: Received slots map to channels in the same order as transmit: the first slot goes to channel 0 for a short pulse and to channel 1 for a long pulse. Each received byte holds its value until that channel's next update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fs_i | input | 1 | Frame sync, synchronous to clk_i |
| dr_i | input | 1 | Serial receive data |
| tx_ch0_i | input | 8 | Transmit word, channel 0 |
| tx_ch1_i | input | 8 | Transmit word, channel 1 |
| dx_o | output | 1 | Serial transmit data |
| dx_en_o | output | 1 | Transmit drive enable (low = high impedance) |
| rx_ch0_o | output | 8 | Received byte, channel 0 |
| rx_ch0_valid_o | output | 1 | One-clock strobe, new channel 0 byte |
| rx_ch1_o | output | 8 | Received byte, channel 1 |
| rx_ch1_valid_o | output | 1 | One-clock strobe, new channel 1 byte |

## Verification
A wrongly latched slot order shows on the first data bit of the frame, one clock after the pulse is detected. It shows again when the valid strobe lands on the wrong channel 9 clocks in. A slot counter that is off by one shifts the enable window, which is seen at clock 1 or clock 17 of the frame. It also shifts every received byte by one bit, which is seen at the first strobe. A frame controller that restarts on a second pulse misplaces data within a few clocks of that pulse. The bench sweeps pulse widths, re-pulses, arithmetic data patterns and input changes during a frame, and compares each bit time against values computed in the bench.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } frame_state_e;
endpackage

// File: rtl/pcm_frame_ctrl.sv
module pcm_frame_ctrl
  import pcm_tdm_pkg::*;
#(
  parameter int unsigned SLOT_W = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                fs_i,
  output logic                                load_o,
  output logic                                start_o,
  output logic                                run_o,
  output logic                                last_o,
  output logic                                slot_done_o,
  output logic                                slot_sel_o,
  output logic                                swap_o
);
  localparam int unsigned FRAME_BITS = 2 * SLOT_W;
  localparam int unsigned POS_W      = $clog2(FRAME_BITS);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] POS_MID  = POS_W'(SLOT_W - 1);

  frame_state_e     state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             fs_q;
  logic             swap_q, swap_d;
  logic             fs_rise;

  assign fs_rise = fs_i & ~fs_q;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    swap_d  = swap_q;
    unique case (state_q)
      ST_IDLE: if (fs_rise) state_d = ST_ARM;
      ST_ARM: begin
        swap_d  = fs_i;  // pulse still high on second edge -> channel 1 first
        pos_d   = '0;
        state_d = ST_RUN;
      end
      ST_RUN: begin
        if (pos_q == POS_LAST) state_d = ST_IDLE;
        else                   pos_d   = pos_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      fs_q    <= 1'b0;
      swap_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      fs_q    <= fs_i;
      swap_q  <= swap_d;
    end
  end

  assign load_o      = (state_q == ST_IDLE) & fs_rise;
  assign start_o     = (state_q == ST_ARM);
  assign run_o       = (state_q == ST_RUN);
  assign last_o      = run_o & (pos_q == POS_LAST);
  assign slot_done_o = run_o & ((pos_q == POS_MID) | (pos_q == POS_LAST));
  assign slot_sel_o  = (pos_q > POS_MID);
  assign swap_o      = start_o ? fs_i : swap_q;

  // R7
  frame_no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && pos_q != POS_LAST) |=> (state_q == ST_RUN && pos_q == $past(pos_q) + 1'b1));
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer #(
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              start_i,
  input  logic              run_i,
  input  logic              last_i,
  input  logic              swap_i,
  input  logic [SLOT_W-1:0] ch0_i,
  input  logic [SLOT_W-1:0] ch1_i,
  output logic              dx_o,
  output logic              dx_en_o
);
  localparam int unsigned FRAME_BITS = 2 * SLOT_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 2);

  logic [SLOT_W-1:0]     word0_q, word1_q;
  logic [FRAME_BITS-1:0] frame_w;
  logic [FRAME_BITS-1:0] sh_q;
  logic                  dx_q, en_q;

  assign frame_w = swap_i ? {word1_q, word0_q} : {word0_q, word1_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word0_q <= '0;
      word1_q <= '0;
    end else if (load_i) begin
      word0_q <= ch0_i;
      word1_q <= ch1_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      dx_q <= 1'b0;
      en_q <= 1'b0;
    end else if (start_i) begin
      dx_q <= frame_w[FRAME_BITS-1];
      sh_q <= {frame_w[FRAME_BITS-2:0], 1'b0};
      en_q <= 1'b1;
    end else if (run_i) begin
      if (last_i) begin
        dx_q <= 1'b0;
        en_q <= 1'b0;
      end else begin
        dx_q <= sh_q[FRAME_BITS-1];
        sh_q <= {sh_q[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  assign dx_o    = dx_q;
  assign dx_en_o = en_q;

  logic [CNT_W-1:0] en_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_cnt_q <= '0;
    else if (en_q) en_cnt_q <= en_cnt_q + 1'b1;
    else           en_cnt_q <= '0;
  end

  // R1
  en_window_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_cnt_q <= CNT_W'(FRAME_BITS));
  // R1
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !start_i) |=> !dx_o);
endmodule

// File: rtl/pcm_rx_deserializer.sv
module pcm_rx_deserializer #(
  parameter int unsigned SLOT_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   dr_i,
  input  logic                   run_i,
  input  logic                   slot_done_i,
  input  logic                   slot_sel_i,
  input  logic                   swap_i,
  output logic [1:0][SLOT_W-1:0] data_o,
  output logic [1:0]             valid_o
);
  logic              dr_neg_q;
  logic [SLOT_W-1:0] sh_q;
  logic [SLOT_W-1:0] byte_w;
  logic              dest_ch;

  // mid-bit capture on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dr_neg_q <= 1'b0;
    else         dr_neg_q <= dr_i;
  end

  assign byte_w  = {sh_q[SLOT_W-2:0], dr_neg_q};
  assign dest_ch = slot_sel_i ^ swap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (run_i) sh_q <= byte_w;
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[ch]  <= '0;
        valid_o[ch] <= 1'b0;
      end else if (slot_done_i && (dest_ch == 1'(ch))) begin
        data_o[ch]  <= byte_w;
        valid_o[ch] <= 1'b1;
      end else begin
        valid_o[ch] <= 1'b0;
      end
    end

    // R9
    hold_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o[ch] |-> $stable(data_o[ch]));
  end
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port #(
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_i,
  input  logic              dr_i,
  input  logic [SLOT_W-1:0] tx_ch0_i,
  input  logic [SLOT_W-1:0] tx_ch1_i,
  output logic              dx_o,
  output logic              dx_en_o,
  output logic [SLOT_W-1:0] rx_ch0_o,
  output logic              rx_ch0_valid_o,
  output logic [SLOT_W-1:0] rx_ch1_o,
  output logic              rx_ch1_valid_o
);
  logic load, start, run, last, slot_done, slot_sel, swap;
  logic [1:0][SLOT_W-1:0] rx_data;
  logic [1:0]             rx_valid;

  pcm_frame_ctrl #(.SLOT_W(SLOT_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fs_i        (fs_i),
    .load_o      (load),
    .start_o     (start),
    .run_o       (run),
    .last_o      (last),
    .slot_done_o (slot_done),
    .slot_sel_o  (slot_sel),
    .swap_o      (swap)
  );

  pcm_tx_serializer #(.SLOT_W(SLOT_W)) i_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .start_i (start),
    .run_i   (run),
    .last_i  (last),
    .swap_i  (swap),
    .ch0_i   (tx_ch0_i),
    .ch1_i   (tx_ch1_i),
    .dx_o    (dx_o),
    .dx_en_o (dx_en_o)
  );

  pcm_rx_deserializer #(.SLOT_W(SLOT_W)) i_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dr_i        (dr_i),
    .run_i       (run),
    .slot_done_i (slot_done),
    .slot_sel_i  (slot_sel),
    .swap_i      (swap),
    .data_o      (rx_data),
    .valid_o     (rx_valid)
  );

  assign rx_ch0_o       = rx_data[0];
  assign rx_ch1_o       = rx_data[1];
  assign rx_ch0_valid_o = rx_valid[0];
  assign rx_ch1_valid_o = rx_valid[1];

  // R1
  start_enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> dx_en_o);
  // R4
  delayed_first_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dx_en_o) |-> $past(fs_i, 2));
  // R6
  strobe_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_ch1_valid_o, rx_ch0_valid_o}));
endmodule

// File: tb/test_pcm_tdm_port.sv
module test_pcm_tdm_port;
  logic       clk_i = 1'b0;
  logic       rst_ni, fs_i, dr_i;
  logic [7:0] tx_ch0_i, tx_ch1_i;
  logic       dx_o, dx_en_o;
  logic [7:0] rx_ch0_o, rx_ch1_o;
  logic       rx_ch0_valid_o, rx_ch1_valid_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pcm_tdm_port i_pcm_tdm_port (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fs_i           (fs_i),
    .dr_i           (dr_i),
    .tx_ch0_i       (tx_ch0_i),
    .tx_ch1_i       (tx_ch1_i),
    .dx_o           (dx_o),
    .dx_en_o        (dx_en_o),
    .rx_ch0_o       (rx_ch0_o),
    .rx_ch0_valid_o (rx_ch0_valid_o),
    .rx_ch1_o       (rx_ch1_o),
    .rx_ch1_valid_o (rx_ch1_valid_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // plen: edges the pulse is sampled high; glitch: extra rise mid-frame
  task automatic do_frame(input int plen, input bit glitch,
                          input logic [7:0] w0, input logic [7:0] w1,
                          input logic [7:0] r0, input logic [7:0] r1);
    bit          lng = (plen >= 2);
    logic [15:0] ftx = lng ? {w1, w0} : {w0, w1};
    logic [15:0] frx = {r0, r1};
    int          chf = lng ? 1 : 0;
    fs_i     = 1'b1;
    tx_ch0_i = w0;
    tx_ch1_i = w1;
    for (int c = 0; c < 20; c++) begin
      @(posedge clk_i);
      #1;
      dr_i = (c >= 1 && c <= 16) ? frx[16-c] : 1'b0;
      if (c == 0) begin
        tx_ch0_i = ~w0;          // R5: late change must not leak
        tx_ch1_i = w1 ^ 8'h5A;
      end
      @(negedge clk_i);
      if (c >= 1 && c <= 16) begin
        chk("R1 enable in window", int'(dx_en_o), 1);
        if (c == 1)  chk("R4 first bit one clock after sync", int'(dx_o), int'(ftx[15]));
        if (lng)     chk("R3 long pulse ch1-first bit", int'(dx_o), int'(ftx[16-c]));
        else         chk("R2 short pulse ch0-first bit", int'(dx_o), int'(ftx[16-c]));
        if (c == 7)  chk("R5 word latched at sync", int'(dx_o), int'(ftx[9]));
        if (glitch && c == 8) chk("R7 mid-frame rise ignored", int'(dx_o), int'(ftx[8]));
      end else begin
        chk("R1 enable off", int'(dx_en_o), 0);
        chk("R1 data low when off", int'(dx_o), 0);
      end
      chk("R6 ch0 strobe timing", int'(rx_ch0_valid_o),
          int'((c == 9 && chf == 0) || (c == 17 && chf == 1)));
      chk("R6 ch1 strobe timing", int'(rx_ch1_valid_o),
          int'((c == 9 && chf == 1) || (c == 17 && chf == 0)));
      if (c == 9)
        chk("R9 first slot byte", chf ? int'(rx_ch1_o) : int'(rx_ch0_o), int'(r0));
      if (c == 17)
        chk("R9 second slot byte", chf ? int'(rx_ch0_o) : int'(rx_ch1_o), int'(r1));
      if (c == 19) begin
        chk("R9 ch0 byte held", int'(rx_ch0_o), chf ? int'(r1) : int'(r0));
        chk("R9 ch1 byte held", int'(rx_ch1_o), chf ? int'(r0) : int'(r1));
      end
      fs_i = ((c + 1) < plen) || (glitch && (c == 5 || c == 6));
    end
  endtask

  initial begin
    rst_ni = 1'b0; fs_i = 1'b0; dr_i = 1'b0;
    tx_ch0_i = '0; tx_ch1_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R8 reset enable", int'(dx_en_o), 0);
    chk("R8 reset data", int'(dx_o), 0);
    chk("R8 reset strobes", int'({rx_ch1_valid_o, rx_ch0_valid_o}), 0);
    chk("R8 reset bytes", int'({rx_ch1_o, rx_ch0_o}), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk("R1 idle without sync", int'(dx_en_o), 0);
    end
    do_frame(1, 1'b0, 8'hFF, 8'h00, 8'h80, 8'h01);
    do_frame(2, 1'b0, 8'hFF, 8'h00, 8'h80, 8'h01);
    for (int n = 0; n < 48; n++) begin
      int plen;
      case (n % 6)
        0: plen = 1;
        1: plen = 2;
        2: plen = 3;
        3: plen = 5;
        4: plen = 16;
        default: plen = 1;
      endcase
      do_frame(plen, (n % 6 == 5) || (n % 12 == 3),
               8'((n * 37 + 5) & 255), 8'((n * 91 + 200) & 255),
               8'((n * 53 + 17) & 255), 8'((n * 29 + 99) & 255));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule